// File: doc/BRIEF.md
# Per-Leaf Batched Read Prefetcher

This block feeds the leaves of a merge tree from external memory. Each leaf owns a contiguous segment of memory, given as a base word address and a length in records, and a private on-chip buffer that holds two batches. Whenever a leaf's buffer has room for a whole batch and its segment is not yet used up, the leaf raises a refill request. A round-robin arbiter picks one requesting leaf per free slot and issues a single sequential burst read for it. Memory therefore only ever sees batch-sized sequential accesses, apart from a trimmed final burst per segment.

Records reach each leaf on a valid/ready stream. A leaf whose segment has been fully delivered raises an end-of-run flag. On the output side, merged records are gathered into a batch buffer and written back as one burst command followed by its data beats. A partial batch is flushed when the record marked last arrives. A `start` pulse loads the segment descriptors and the write base address.

The memory side is a plain burst interface. A request carries the address, length and leaf index and is held until accepted. Response beats arrive one per cycle, tagged with the leaf index, and are never back-pressured, because the space for them was reserved when the request was granted.

Top module: `leaf_prefetch_loader`

## Requirements
- R1: Every read burst length equals the smaller of the batch size (BATCH records) and the records still unrequested in that leaf's segment, so it always lies between 1 and BATCH.
- R2: The read requests of one leaf carry consecutive word addresses, starting at that leaf's segment base. A request that is not accepted keeps its address, length and leaf index unchanged.
- R3: A leaf never has more than one read burst outstanding, and its buffered plus reserved records never exceed 2*BATCH.
- R4: Leaf i receives on lane bits [i*DATA_W +: DATA_W] exactly its segment length in records, in increasing address order. The response beats are routed by `rd_rsp_leaf`, which holds the leaf index.
- R5: `leaf_end[i]` is high exactly when a run has started and every record of segment i has been handed over. A zero-length segment ends in the first cycle after `start`.
- R6: Write commands carry consecutive addresses, starting at `wr_base` and advancing by the previous command's length. Every command except the last of a run has length BATCH, and a command is held until accepted.
- R7: When the record flagged `rec_last` is accepted, a partially filled batch is written with its length trimmed to the records it holds.
- R8: After each write command, exactly its length in data beats follow, carrying the records in arrival order.
- R9: During and right after reset there is no read request, no leaf record, no end-of-run flag, no write command and no write beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Loads segment descriptors and write base |
| seg_base | input | LEAVES*ADDR_W | Per-leaf segment base word address |
| seg_len | input | LEAVES*LEN_W | Per-leaf segment length in records |
| wr_base | input | ADDR_W | First write address of the output |
| rd_req_valid | output | 1 | Read burst request pending |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | ADDR_W | Burst start word address |
| rd_req_len | output | BL_W | Burst length in records |
| rd_req_leaf | output | LID_W | Leaf that owns the burst |
| rd_rsp_valid | input | 1 | Read data beat present |
| rd_rsp_leaf | input | LID_W | Leaf that the beat belongs to |
| rd_rsp_data | input | DATA_W | Read data beat |
| leaf_valid | output | LEAVES | Record available per leaf |
| leaf_data | output | LEAVES*DATA_W | Record per leaf |
| leaf_ready | input | LEAVES | Leaf takes the record |
| leaf_end | output | LEAVES | Segment fully delivered |
| rec_valid | input | 1 | Output record offered |
| rec_ready | output | 1 | Output record accepted |
| rec_data | input | DATA_W | Output record |
| rec_last | input | 1 | Final output record of the run |
| wr_cmd_valid | output | 1 | Write burst command pending |
| wr_cmd_ready | input | 1 | Memory accepts the write command |
| wr_cmd_addr | output | ADDR_W | Write burst start address |
| wr_cmd_len | output | BL_W | Write burst length in records |
| wr_beat_valid | output | 1 | Write data beat present |
| wr_beat_ready | input | 1 | Memory takes the write beat |
| wr_beat_data | output | DATA_W | Write data beat |

## Verification
A granted refill appears on the request port one cycle after the arbitration decision. A response beat written into a buffer reaches the leaf output register one cycle later. The end-of-run flag follows the consuming handshake by one edge, and a write command follows the batch-closing record by one edge. The bench drives inputs at the falling edge and settles briefly before it evaluates each handshake against the values present ahead of the next rising edge. It updates its queue-based model at that point and compares the end-of-run flags against the model on every falling edge. This way every expected value refers to the cycle in which the design is due to change. A memory model with random acceptance, random first-beat delay and random gaps exercises the latency spread.

// File: rtl/lpl_pkg.sv
package lpl_pkg;

  typedef enum logic [1:0] {
    WS_FILL = 2'd0,
    WS_CMD  = 2'd1,
    WS_BEAT = 2'd2
  } wr_state_e;

endpackage

// File: rtl/lpl_leaf_buffer.sv
module lpl_leaf_buffer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 16,
  parameter int BATCH  = 8,
  parameter int DEPTH  = 16,
  parameter int BL_W   = $clog2(BATCH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [LEN_W-1:0]  seg_len,
  output logic              want,
  input  logic              grant,
  output logic [ADDR_W-1:0] req_addr,
  output logic [BL_W-1:0]   req_len,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              lf_valid,
  output logic [DATA_W-1:0] lf_data,
  input  logic              lf_ready,
  output logic              lf_end
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  remain_q;
  logic [CNT_W-1:0]  used_q;
  logic [BL_W-1:0]   beats_q;
  logic              run_q;

  logic [DATA_W-1:0] ram [DEPTH];
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [CNT_W-1:0]  fill_q;
  logic              ov_q;
  logic [DATA_W-1:0] od_q;

  logic pop, load;

  assign pop  = ov_q & lf_ready;
  assign load = (fill_q != '0) & (~ov_q | pop);

  assign req_addr = addr_q;
  assign req_len  = (remain_q < LEN_W'(BATCH)) ? BL_W'(remain_q) : BL_W'(BATCH);
  assign want     = run_q && (remain_q != '0) && (beats_q == '0) &&
                    ((CNT_W'(DEPTH) - used_q) >= CNT_W'(BATCH));
  assign lf_end   = run_q && (remain_q == '0) && (used_q == '0);
  assign lf_valid = ov_q;
  assign lf_data  = od_q;

  // segment cursor, space reservation and burst tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      remain_q <= '0;
      used_q   <= '0;
      beats_q  <= '0;
      run_q    <= 1'b0;
    end else if (start) begin
      addr_q   <= seg_base;
      remain_q <= seg_len;
      used_q   <= '0;
      beats_q  <= '0;
      run_q    <= 1'b1;
    end else begin
      if (grant) begin
        addr_q   <= addr_q + ADDR_W'(req_len);
        remain_q <= remain_q - LEN_W'(req_len);
      end
      used_q <= used_q + (grant ? CNT_W'(req_len) : '0) - CNT_W'(pop);
      if (grant) beats_q <= req_len;
      else if (rsp_valid) beats_q <= beats_q - BL_W'(1);
    end
  end

  // storage: plain write port and registered read port
  always_ff @(posedge clk) begin
    if (rsp_valid) ram[wp_q] <= rsp_data;
    if (load) od_q <= ram[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
      ov_q   <= 1'b0;
    end else begin
      if (rsp_valid) wp_q <= wp_q + PTR_W'(1);
      if (load) rp_q <= rp_q + PTR_W'(1);
      fill_q <= fill_q + CNT_W'(rsp_valid) - CNT_W'(load);
      if (load) ov_q <= 1'b1;
      else if (pop) ov_q <= 1'b0;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    used_q <= CNT_W'(DEPTH));

  assert_rsp_expected_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (beats_q != '0));

  assert_burst_len_R1: assert property (@(posedge clk) disable iff (rst)
    grant |-> (want && (req_len != '0) && (req_len <= BL_W'(BATCH))));

  assert_end_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (lf_end && !start) |=> lf_end);

endmodule

// File: rtl/lpl_rr_arbiter.sv
module lpl_rr_arbiter #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gidx,
  output logic          any
);

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] cand;

  // search starts one past the last winner
  always_comb begin
    gnt  = '0;
    gidx = '0;
    any  = 1'b0;
    cand = '0;
    for (int k = 1; k <= N; k++) begin
      cand = IW'((int'(ptr_q) + k) % N);
      if (!any && take && req[cand]) begin
        gnt[cand] = 1'b1;
        gidx      = cand;
        any       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= IW'(N - 1);
    else if (any) ptr_q <= gidx;
  end

  assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  assert_grant_requested_R3: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);

endmodule

// File: rtl/lpl_write_coalescer.sv
module lpl_write_coalescer
  import lpl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 20,
  parameter int BATCH  = 8,
  parameter int BL_W   = $clog2(BATCH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic [DATA_W-1:0] rec_data,
  input  logic              rec_last,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BL_W-1:0]   cmd_len,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [DATA_W-1:0] beat_data
);

  localparam int PTR_W = $clog2(BATCH);

  wr_state_e         st_q;
  logic [DATA_W-1:0] buf_q [BATCH];
  logic [BL_W-1:0]   cnt_q;
  logic [BL_W-1:0]   left_q;
  logic [PTR_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              bv_q;
  logic [DATA_W-1:0] bd_q;

  logic             accept, cmd_go, beat_go, rd_en;
  logic [PTR_W-1:0] rd_idx;

  assign rec_ready  = (st_q == WS_FILL);
  assign cmd_valid  = (st_q == WS_CMD);
  assign cmd_addr   = addr_q;
  assign cmd_len    = cnt_q;
  assign beat_valid = bv_q;
  assign beat_data  = bd_q;

  assign accept  = rec_valid & rec_ready;
  assign cmd_go  = cmd_valid & cmd_ready;
  assign beat_go = bv_q & beat_ready;
  assign rd_en   = cmd_go | (beat_go & (left_q != BL_W'(1)));
  assign rd_idx  = cmd_go ? '0 : idx_q;

  always_ff @(posedge clk) begin
    if (accept) buf_q[cnt_q[PTR_W-1:0]] <= rec_data;
    if (rd_en) bd_q <= buf_q[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= WS_FILL;
      cnt_q  <= '0;
      left_q <= '0;
      idx_q  <= '0;
      addr_q <= '0;
      bv_q   <= 1'b0;
    end else if (start) begin
      st_q   <= WS_FILL;
      cnt_q  <= '0;
      left_q <= '0;
      idx_q  <= '0;
      addr_q <= wr_base;
      bv_q   <= 1'b0;
    end else begin
      case (st_q)
        WS_FILL: if (accept) begin
          cnt_q <= cnt_q + BL_W'(1);
          if ((cnt_q + BL_W'(1) == BL_W'(BATCH)) || rec_last) st_q <= WS_CMD;
        end
        WS_CMD: if (cmd_ready) begin
          st_q   <= WS_BEAT;
          bv_q   <= 1'b1;
          idx_q  <= PTR_W'(1);
          left_q <= cnt_q;
        end
        WS_BEAT: if (beat_ready) begin
          if (left_q == BL_W'(1)) begin
            bv_q   <= 1'b0;
            st_q   <= WS_FILL;
            addr_q <= addr_q + ADDR_W'(cnt_q);
            cnt_q  <= '0;
          end else begin
            left_q <= left_q - BL_W'(1);
            idx_q  <= idx_q + PTR_W'(1);
          end
        end
        default: st_q <= WS_FILL;
      endcase
    end
  end

  assert_cmd_len_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ((cnt_q != '0) && (cnt_q <= BL_W'(BATCH))));

  assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len)));

  assert_beat_count_R8: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> ((left_q != '0) && (left_q <= cnt_q)));

endmodule

// File: rtl/leaf_prefetch_loader.sv
module leaf_prefetch_loader #(
  parameter int LEAVES = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 16,
  parameter int BATCH  = 8,
  parameter int BL_W   = $clog2(BATCH + 1),
  parameter int LID_W  = (LEAVES > 1) ? $clog2(LEAVES) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [LEAVES*ADDR_W-1:0] seg_base,
  input  logic [LEAVES*LEN_W-1:0]  seg_len,
  input  logic [ADDR_W-1:0]        wr_base,
  output logic                     rd_req_valid,
  input  logic                     rd_req_ready,
  output logic [ADDR_W-1:0]        rd_req_addr,
  output logic [BL_W-1:0]          rd_req_len,
  output logic [LID_W-1:0]         rd_req_leaf,
  input  logic                     rd_rsp_valid,
  input  logic [LID_W-1:0]         rd_rsp_leaf,
  input  logic [DATA_W-1:0]        rd_rsp_data,
  output logic [LEAVES-1:0]        leaf_valid,
  output logic [LEAVES*DATA_W-1:0] leaf_data,
  input  logic [LEAVES-1:0]        leaf_ready,
  output logic [LEAVES-1:0]        leaf_end,
  input  logic                     rec_valid,
  output logic                     rec_ready,
  input  logic [DATA_W-1:0]        rec_data,
  input  logic                     rec_last,
  output logic                     wr_cmd_valid,
  input  logic                     wr_cmd_ready,
  output logic [ADDR_W-1:0]        wr_cmd_addr,
  output logic [BL_W-1:0]          wr_cmd_len,
  output logic                     wr_beat_valid,
  input  logic                     wr_beat_ready,
  output logic [DATA_W-1:0]        wr_beat_data
);

  localparam int DEPTH = 2 * BATCH;

  logic [LEAVES-1:0] want, gnt, rsp_hit;
  logic [ADDR_W-1:0] lb_addr [LEAVES];
  logic [BL_W-1:0]   lb_len  [LEAVES];
  logic [LID_W-1:0]  gidx;
  logic              any;

  logic              rq_v_q;
  logic [ADDR_W-1:0] rq_addr_q;
  logic [BL_W-1:0]   rq_len_q;
  logic [LID_W-1:0]  rq_leaf_q;
  logic [ADDR_W-1:0] sel_addr;
  logic [BL_W-1:0]   sel_len;

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    assign rsp_hit[i] = rd_rsp_valid && (rd_rsp_leaf == LID_W'(i));

    lpl_leaf_buffer #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
      .BATCH(BATCH), .DEPTH(DEPTH), .BL_W(BL_W)
    ) u_buf (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .seg_base (seg_base[i*ADDR_W +: ADDR_W]),
      .seg_len  (seg_len[i*LEN_W +: LEN_W]),
      .want     (want[i]),
      .grant    (gnt[i]),
      .req_addr (lb_addr[i]),
      .req_len  (lb_len[i]),
      .rsp_valid(rsp_hit[i]),
      .rsp_data (rd_rsp_data),
      .lf_valid (leaf_valid[i]),
      .lf_data  (leaf_data[i*DATA_W +: DATA_W]),
      .lf_ready (leaf_ready[i]),
      .lf_end   (leaf_end[i])
    );
  end

  lpl_rr_arbiter #(.N(LEAVES), .IW(LID_W)) u_arb (
    .clk (clk),
    .rst (rst),
    .req (want),
    .take(~rq_v_q),
    .gnt (gnt),
    .gidx(gidx),
    .any (any)
  );

  always_comb begin
    sel_addr = '0;
    sel_len  = '0;
    for (int i = 0; i < LEAVES; i++) begin
      if (gnt[i]) begin
        sel_addr = lb_addr[i];
        sel_len  = lb_len[i];
      end
    end
  end

  // single request slot towards memory
  always_ff @(posedge clk) begin
    if (rst) begin
      rq_v_q    <= 1'b0;
      rq_addr_q <= '0;
      rq_len_q  <= '0;
      rq_leaf_q <= '0;
    end else if (rq_v_q) begin
      if (rd_req_ready) rq_v_q <= 1'b0;
    end else if (any) begin
      rq_v_q    <= 1'b1;
      rq_addr_q <= sel_addr;
      rq_len_q  <= sel_len;
      rq_leaf_q <= gidx;
    end
  end

  assign rd_req_valid = rq_v_q;
  assign rd_req_addr  = rq_addr_q;
  assign rd_req_len   = rq_len_q;
  assign rd_req_leaf  = rq_leaf_q;

  lpl_write_coalescer #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BATCH(BATCH), .BL_W(BL_W)
  ) u_wr (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .wr_base   (wr_base),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .rec_data  (rec_data),
    .rec_last  (rec_last),
    .cmd_valid (wr_cmd_valid),
    .cmd_ready (wr_cmd_ready),
    .cmd_addr  (wr_cmd_addr),
    .cmd_len   (wr_cmd_len),
    .beat_valid(wr_beat_valid),
    .beat_ready(wr_beat_ready),
    .beat_data (wr_beat_data)
  );

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && !rd_req_ready) |=>
      (rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len) && $stable(rd_req_leaf)));

  assert_req_leaf_range_R4: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> (int'(rd_req_leaf) < LEAVES));

endmodule

// File: tb/leaf_prefetch_loader_bench.sv
module leaf_prefetch_loader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LEAVES = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 20;
  localparam int LEN_W  = 16;
  localparam int BATCH  = 8;
  localparam int BL_W   = $clog2(BATCH + 1);
  localparam int LID_W  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [LEAVES*ADDR_W-1:0] seg_base = '0;
  logic [LEAVES*LEN_W-1:0]  seg_len = '0;
  logic [ADDR_W-1:0]        wr_base = '0;
  logic                     rd_req_valid;
  logic                     rd_req_ready = 1'b0;
  logic [ADDR_W-1:0]        rd_req_addr;
  logic [BL_W-1:0]          rd_req_len;
  logic [LID_W-1:0]         rd_req_leaf;
  logic                     rd_rsp_valid = 1'b0;
  logic [LID_W-1:0]         rd_rsp_leaf = '0;
  logic [DATA_W-1:0]        rd_rsp_data = '0;
  logic [LEAVES-1:0]        leaf_valid;
  logic [LEAVES*DATA_W-1:0] leaf_data;
  logic [LEAVES-1:0]        leaf_ready = '0;
  logic [LEAVES-1:0]        leaf_end;
  logic                     rec_valid = 1'b0;
  logic                     rec_ready;
  logic [DATA_W-1:0]        rec_data = '0;
  logic                     rec_last = 1'b0;
  logic                     wr_cmd_valid;
  logic                     wr_cmd_ready = 1'b0;
  logic [ADDR_W-1:0]        wr_cmd_addr;
  logic [BL_W-1:0]          wr_cmd_len;
  logic                     wr_beat_valid;
  logic                     wr_beat_ready = 1'b0;
  logic [DATA_W-1:0]        wr_beat_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  leaf_prefetch_loader #(
    .LEAVES(LEAVES), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .BATCH(BATCH), .BL_W(BL_W), .LID_W(LID_W)
  ) u_leaf_prefetch_loader (
    .clk(clk), .rst(rst), .start(start), .seg_base(seg_base), .seg_len(seg_len),
    .wr_base(wr_base), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len), .rd_req_leaf(rd_req_leaf),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_leaf(rd_rsp_leaf), .rd_rsp_data(rd_rsp_data),
    .leaf_valid(leaf_valid), .leaf_data(leaf_data), .leaf_ready(leaf_ready),
    .leaf_end(leaf_end), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_data(rec_data), .rec_last(rec_last), .wr_cmd_valid(wr_cmd_valid),
    .wr_cmd_ready(wr_cmd_ready), .wr_cmd_addr(wr_cmd_addr), .wr_cmd_len(wr_cmd_len),
    .wr_beat_valid(wr_beat_valid), .wr_beat_ready(wr_beat_ready),
    .wr_beat_data(wr_beat_data)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // model state
  int  base_m [LEAVES];
  int  len_m  [LEAVES];
  int  exp_addr [LEAVES];
  int  got [LEAVES];
  bit  busy [LEAVES];
  bit  started = 1'b0;
  int  q_leaf [$];
  int  q_addr [$];
  int  q_len  [$];
  bit  r_active = 1'b0;
  int  r_leaf, r_addr, r_left, r_wait;
  int  ec_addr [$];
  int  ec_len  [$];
  int  eb_data [$];
  int  w_total = 0;
  int  w_sent = 0;
  int  run_id = 0;

  function automatic logic [DATA_W-1:0] mem_word(int a);
    return DATA_W'(a * 40503 + 17);
  endfunction

  function automatic int rec_word(int i);
    return run_id * 1000 + i * 3 + 100;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit all_done();
    for (int i = 0; i < LEAVES; i++) if (got[i] != len_m[i]) return 1'b0;
    return (w_sent == w_total) && (ec_addr.size() == 0) && (eb_data.size() == 0) &&
           !r_active && (q_leaf.size() == 0);
  endfunction

  task automatic step();
    int a, l, e;
    @(negedge clk);
    // R5: end-of-run compared every clock
    for (int i = 0; i < LEAVES; i++)
      chk(leaf_end[i] == (started && got[i] == len_m[i]), "R5", "leaf end flag",
          longint'(leaf_end[i]), longint'(started && got[i] == len_m[i]));
    // drive next inputs
    rd_req_ready  = ($urandom_range(0, 3) != 0);
    wr_cmd_ready  = ($urandom_range(0, 2) != 0);
    wr_beat_ready = ($urandom_range(0, 3) != 0);
    for (int i = 0; i < LEAVES; i++) leaf_ready[i] = ($urandom_range(0, 2) != 0);
    rd_rsp_valid = 1'b0;
    if (!r_active && q_leaf.size() > 0) begin
      r_leaf = q_leaf.pop_front();
      r_addr = q_addr.pop_front();
      r_left = q_len.pop_front();
      r_wait = $urandom_range(0, 4);
      r_active = 1'b1;
    end else if (r_active) begin
      if (r_wait > 0) r_wait--;
      else if ($urandom_range(0, 4) != 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_leaf  = LID_W'(r_leaf);
        rd_rsp_data  = mem_word(r_addr);
        r_addr++;
        r_left--;
        if (r_left == 0) begin
          r_active = 1'b0;
          busy[r_leaf] = 1'b0;
        end
      end
    end
    if (w_sent < w_total) begin
      rec_valid = ($urandom_range(0, 1) != 0);
      rec_data  = DATA_W'(rec_word(w_sent));
      rec_last  = (w_sent == w_total - 1);
    end else begin
      rec_valid = 1'b0;
      rec_last  = 1'b0;
    end
    #1;
    // handshakes that take place at the coming rising edge
    if (rd_req_valid && rd_req_ready) begin
      l = int'(rd_req_leaf);
      e = len_m[l] - (exp_addr[l] - base_m[l]);
      if (e > BATCH) e = BATCH;
      chk(int'(rd_req_len) == e, "R1", "burst length", longint'(rd_req_len), longint'(e));
      chk(int'(rd_req_addr) == exp_addr[l], "R2", "burst address",
          longint'(rd_req_addr), longint'(exp_addr[l]));
      chk(!busy[l], "R3", "second outstanding burst", longint'(busy[l]), 0);
      busy[l] = 1'b1;
      q_leaf.push_back(l);
      q_addr.push_back(int'(rd_req_addr));
      q_len.push_back(int'(rd_req_len));
      exp_addr[l] = exp_addr[l] + int'(rd_req_len);
    end
    for (int i = 0; i < LEAVES; i++) begin
      if (leaf_valid[i] && leaf_ready[i]) begin
        chk(got[i] < len_m[i], "R4", "record beyond segment", longint'(got[i]), longint'(len_m[i]));
        chk(leaf_data[i*DATA_W +: DATA_W] == mem_word(base_m[i] + got[i]), "R4", "leaf record",
            longint'(leaf_data[i*DATA_W +: DATA_W]), longint'(mem_word(base_m[i] + got[i])));
        got[i]++;
      end
    end
    if (wr_cmd_valid && wr_cmd_ready) begin
      if (ec_addr.size() == 0) chk(1'b0, "R6", "unexpected write command", longint'(wr_cmd_addr), -1);
      else begin
        a = ec_addr.pop_front();
        l = ec_len.pop_front();
        chk(int'(wr_cmd_addr) == a, "R6", "write address", longint'(wr_cmd_addr), longint'(a));
        chk(int'(wr_cmd_len) == l, "R7", "write length", longint'(wr_cmd_len), longint'(l));
      end
    end
    if (wr_beat_valid && wr_beat_ready) begin
      if (eb_data.size() == 0) chk(1'b0, "R8", "unexpected write beat", longint'(wr_beat_data), -1);
      else begin
        a = eb_data.pop_front();
        chk(wr_beat_data == DATA_W'(a), "R8", "write beat", longint'(wr_beat_data), longint'(a));
      end
    end
    if (rec_valid && rec_ready) w_sent++;
  endtask

  task automatic run(input int lens [LEAVES], input int wbase, input int nrec);
    int guard, left, adr;
    @(negedge clk);
    rd_req_ready = 1'b0; leaf_ready = '0; rd_rsp_valid = 1'b0; rec_valid = 1'b0;
    wr_cmd_ready = 1'b0; wr_beat_ready = 1'b0;
    run_id++;
    for (int i = 0; i < LEAVES; i++) begin
      seg_base[i*ADDR_W +: ADDR_W] = ADDR_W'(run_id * 4096 + i * 600 + 3);
      seg_len[i*LEN_W +: LEN_W]    = LEN_W'(lens[i]);
    end
    wr_base = ADDR_W'(wbase);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < LEAVES; i++) begin
      base_m[i] = run_id * 4096 + i * 600 + 3;
      len_m[i] = lens[i];
      exp_addr[i] = base_m[i];
      got[i] = 0;
      busy[i] = 1'b0;
    end
    started = 1'b1;
    w_total = nrec;
    w_sent = 0;
    left = nrec;
    adr = wbase;
    while (left > 0) begin
      ec_addr.push_back(adr);
      ec_len.push_back(left > BATCH ? BATCH : left);
      adr += (left > BATCH ? BATCH : left);
      left -= (left > BATCH ? BATCH : left);
    end
    for (int i = 0; i < nrec; i++) eb_data.push_back(rec_word(i));
    guard = 0;
    while (!all_done() && guard < 20000) begin
      step();
      guard++;
    end
    for (int k = 0; k < 6; k++) step();
    for (int i = 0; i < LEAVES; i++) begin
      chk(got[i] == len_m[i], "R4", "records delivered", longint'(got[i]), longint'(len_m[i]));
      chk(exp_addr[i] == base_m[i] + len_m[i], "R2", "segment fully requested",
          longint'(exp_addr[i]), longint'(base_m[i] + len_m[i]));
    end
    chk(ec_addr.size() == 0, "R7", "write commands pending", longint'(ec_addr.size()), 0);
    chk(eb_data.size() == 0, "R8", "write beats pending", longint'(eb_data.size()), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int la [LEAVES];
    int lb [LEAVES];
    int lc [LEAVES];
    for (int i = 0; i < LEAVES; i++) begin
      len_m[i] = 0; got[i] = 0; base_m[i] = 0; exp_addr[i] = 0; busy[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R9: state while reset is applied
    chk(!rd_req_valid, "R9", "read request in reset", longint'(rd_req_valid), 0);
    chk(leaf_valid == '0, "R9", "leaf valid in reset", longint'(leaf_valid), 0);
    chk(leaf_end == '0, "R9", "leaf end in reset", longint'(leaf_end), 0);
    chk(!wr_cmd_valid && !wr_beat_valid, "R9", "write activity in reset",
        longint'({wr_cmd_valid, wr_beat_valid}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rd_req_valid && leaf_valid == '0 && leaf_end == '0 && !wr_cmd_valid, "R9",
        "idle after reset", longint'({rd_req_valid, leaf_valid, leaf_end, wr_cmd_valid}), 0);
    // long, exact-batch, empty and short segments; partial final write batch
    la = '{20, 8, 0, 3};
    run(la, 5000, 19);
    // single-record segment and write exactly one full batch
    lb = '{5, 16, 1, 13};
    run(lb, 7000, 8);
    // mostly empty segments, single output record
    lc = '{9, 0, 0, 2};
    run(lc, 9000, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule